// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for a pin count that is a multiple of 32. Pins are organised in banks of 32. For every bank, software sees one 32-bit word per feature: the synchronized input level, the pin direction, a write-one-to-set and a write-one-to-clear strobe for the output value, rising and falling edge enables, and a sticky edge status word. A further group of words holds a two-bit alternate-function code per pin, which the block stores and presents on an output bus for the pad multiplexer.

Pin inputs cross into the clock domain through a two-flop synchronizer. An edge is detected by comparing the synchronized level with its value one cycle earlier. Any enabled edge sets its status bit, which stays set until software writes a one to it. A single registered interrupt line is high while any status bit in any bank is set. The register interface is a plain single-cycle write port and a combinational read port.

Top module: `gpio_ctrl`

## Requirements
- R1: Registers are addressed by byte address = (feature × NBANK + index) × 4, with NBANK = NGPIO/32 and the feature numbers 0 level, 1 direction, 2 set, 3 clear, 4 rising-enable, 5 falling-enable, 6 edge-status, 7 alternate-function; features 0 to 6 have NBANK words (index = pin/32, bit = pin%32) and feature 7 has 2×NBANK words.
- R2: A level word read returns the input pins of its bank after two synchronizer stages; a change on pin_in before clock edge k is visible on reg_rdata after edge k+1.
- R3: A direction bit of 1 drives the matching pin_oe bit high (output); 0 keeps it low (input).
- R4: Writing a 1 to a set-word bit drives that pin_out bit to 1 and writing a 1 to a clear-word bit drives it to 0, from the next edge; zero bits leave pin_out unchanged; set and clear words read as zero.
- R5: With the rising-enable bit set, a low-to-high change of the synchronized level sets the pin's status bit; with it clear, no status is set by a rising change.
- R6: With the falling-enable bit set, a high-to-low change of the synchronized level sets the pin's status bit; both enables may be set together.
- R7: A status bit stays set until a 1 is written to it in the status word; a 0 bit in that write has no effect; an edge detected in the same cycle as the clearing write leaves the bit set.
- R8: irq is a register that goes high one cycle after any status bit is set and low one cycle after all are clear.
- R9: The alternate-function code of pin p sits in word p/16 of feature 7 at bits (p%16)×2+1:(p%16)×2 and drives alt_sel[2p+1:2p]; it reads back as written.
- R10: After reset the direction, output, both enable, status and alternate-function registers are zero, and irq is low.
- R11: Writes to level words or to undefined addresses change no state; reads of undefined addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the accessed word |
| reg_wen | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pin_in | input | NGPIO | Asynchronous pin inputs |
| pin_oe | output | NGPIO | Per-pin output enable (1 = drive) |
| pin_out | output | NGPIO | Per-pin output value |
| alt_sel | output | 2×NGPIO | Stored alternate-function codes, two bits per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The case hardest to reach from the ports is an edge that is detected in exactly the cycle a clearing write to the same status bit is sampled, because the edge reaches the detector only after two synchronizer stages. The bench toggles a pin with the edge enabled, waits two clock edges so that the detector fires in the write's sampling cycle, and then issues the clearing write; the status bit must read back as set. Every other output is compared each cycle against a behavioural model that decodes addresses with its own arithmetic.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  typedef enum logic [2:0] {
    FEAT_LEVEL = 3'd0,
    FEAT_DIR   = 3'd1,
    FEAT_SET   = 3'd2,
    FEAT_CLR   = 3'd3,
    FEAT_RISE  = 3'd4,
    FEAT_FALL  = 3'd5,
    FEAT_STAT  = 3'd6,
    FEAT_ALT   = 3'd7
  } feat_e;

  localparam int unsigned BANK_W = 32;

  // word index of word 'idx' of feature 'f' when each feature spans nbank words
  function automatic int unsigned word_of(input feat_e f, input int unsigned idx,
                                          input int unsigned nbank);
    return int'(f) * nbank + idx;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lvl,
  input  logic              dir_we,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              rise_we,
  input  logic              fall_we,
  input  logic              stat_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] out_q,
  output logic [BANK_W-1:0] rise_q,
  output logic [BANK_W-1:0] fall_q,
  output logic [BANK_W-1:0] stat_q
);
  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] went_up, went_down, edge_hit, stat_clr;

  assign went_up   = lvl & ~prev_q;
  assign went_down = ~lvl & prev_q;
  assign edge_hit  = (went_up & rise_q) | (went_down & fall_q);
  assign stat_clr  = stat_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl;
      if (dir_we)  dir_q  <= wdata;
      if (rise_we) rise_q <= wdata;
      if (fall_we) fall_q <= wdata;
      if (set_we)       out_q <= out_q | wdata;
      else if (clr_we)  out_q <= out_q & ~wdata;
      // a fresh edge overrides a clear aimed at the same bit
      stat_q <= (stat_q & ~stat_clr) | edge_hit;
    end
  end

  assert_edge_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != '0) |=> ((stat_q & $past(stat_q & ~stat_clr)) == $past(stat_q & ~stat_clr)));

  assert_set_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((out_q & $past(wdata)) == $past(wdata)));

  assert_clr_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((out_q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_altfn.sv
module gpio_altfn
  import gpio_regs_pkg::*;
#(
  parameter int NWORD = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NWORD-1:0]          we,
  input  logic [BANK_W-1:0]         wdata,
  output logic [NWORD*BANK_W-1:0]   alt_q
);
  for (genvar w = 0; w < NWORD; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)     alt_q[w*BANK_W +: BANK_W] <= '0;
      else if (we[w]) alt_q[w*BANK_W +: BANK_W] <= wdata;
    end

    assert_alt_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      we[w] |=> (alt_q[w*BANK_W +: BANK_W] == $past(wdata)));
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_regs_pkg::*;
#(
  parameter  int NGPIO  = 64,
  localparam int NBANK  = NGPIO / 32,
  localparam int ADDR_W = $clog2(9 * NBANK * 4)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wen,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NGPIO-1:0]     pin_in,
  output logic [NGPIO-1:0]     pin_oe,
  output logic [NGPIO-1:0]     pin_out,
  output logic [2*NGPIO-1:0]   alt_sel,
  output logic                 irq
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int NALT   = 2 * NBANK;

  logic [WORD_W-1:0] word;
  assign word = reg_addr[ADDR_W-1:2];

  function automatic logic sel(input logic [WORD_W-1:0] wd, input feat_e f,
                               input int unsigned idx);
    return wd == WORD_W'(word_of(f, idx, NBANK));
  endfunction

  logic [NGPIO-1:0] lvl_s;
  gpio_sync #(.W(NGPIO)) sync_i (.clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_s));

  logic [BANK_W-1:0] dir_w [NBANK];
  logic [BANK_W-1:0] out_w [NBANK];
  logic [BANK_W-1:0] rise_w[NBANK];
  logic [BANK_W-1:0] fall_w[NBANK];
  logic [BANK_W-1:0] stat_w[NBANK];
  logic [NBANK-1:0]  bank_pend;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    gpio_bank bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl_s[b*BANK_W +: BANK_W]),
      .dir_we (reg_wen && sel(word, FEAT_DIR,  b)),
      .set_we (reg_wen && sel(word, FEAT_SET,  b)),
      .clr_we (reg_wen && sel(word, FEAT_CLR,  b)),
      .rise_we(reg_wen && sel(word, FEAT_RISE, b)),
      .fall_we(reg_wen && sel(word, FEAT_FALL, b)),
      .stat_we(reg_wen && sel(word, FEAT_STAT, b)),
      .wdata  (reg_wdata),
      .dir_q  (dir_w[b]),
      .out_q  (out_w[b]),
      .rise_q (rise_w[b]),
      .fall_q (fall_w[b]),
      .stat_q (stat_w[b])
    );
    assign pin_oe [b*BANK_W +: BANK_W] = dir_w[b];
    assign pin_out[b*BANK_W +: BANK_W] = out_w[b];
    assign bank_pend[b] = |stat_w[b];
  end

  logic [NALT-1:0] alt_we;
  for (genvar w = 0; w < NALT; w++) begin : g_altwe
    assign alt_we[w] = reg_wen && sel(word, FEAT_ALT, w);
  end

  gpio_altfn #(.NWORD(NALT)) alt_i (
    .clk(clk), .rst_n(rst_n), .we(alt_we), .wdata(reg_wdata), .alt_q(alt_sel)
  );

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (sel(word, FEAT_LEVEL, b)) reg_rdata = lvl_s[b*BANK_W +: BANK_W];
      if (sel(word, FEAT_DIR,   b)) reg_rdata = dir_w[b];
      if (sel(word, FEAT_RISE,  b)) reg_rdata = rise_w[b];
      if (sel(word, FEAT_FALL,  b)) reg_rdata = fall_w[b];
      if (sel(word, FEAT_STAT,  b)) reg_rdata = stat_w[b];
    end
    for (int w = 0; w < NALT; w++) begin
      if (sel(word, FEAT_ALT, w)) reg_rdata = alt_sel[w*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |bank_pend;
  end

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_pend) |=> irq);

  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|bank_pend) |=> !irq);
endmodule

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb_top;
  localparam int NGPIO  = 64;
  localparam int NB     = NGPIO / 32;
  localparam int ADDR_W = $clog2(9 * NB * 4);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NGPIO-1:0] pin_in = '0;
  logic [NGPIO-1:0] pin_oe, pin_out;
  logic [2*NGPIO-1:0] alt_sel;
  logic irq;

  always #2.5 clk = ~clk;

  gpio_ctrl #(.NGPIO(NGPIO)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .alt_sel(alt_sel), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference state
  logic [NGPIO-1:0] m_s1, m_s2, m_prev, m_dir, m_out, m_ren, m_fen, m_st;
  logic [2*NGPIO-1:0] m_alt;
  logic m_irq;

  always @(posedge clk) begin : model
    logic [NGPIO-1:0] hits, clr;
    int w;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_dir = '0; m_out = '0;
      m_ren = '0; m_fen = '0; m_st = '0; m_alt = '0; m_irq = 1'b0;
    end else begin
      hits = '0;
      for (int p = 0; p < NGPIO; p++) begin
        if (m_s2[p] && !m_prev[p] && m_ren[p]) hits[p] = 1'b1;
        if (!m_s2[p] && m_prev[p] && m_fen[p]) hits[p] = 1'b1;
      end
      m_irq = (m_st != 0);
      clr = '0;
      if (reg_wen) begin
        w = int'(reg_addr) / 4;
        if (w < 7 * NB) begin
          case (w / NB)
            1: m_dir[(w % NB)*32 +: 32] = reg_wdata;
            2: m_out[(w % NB)*32 +: 32] = m_out[(w % NB)*32 +: 32] | reg_wdata;
            3: m_out[(w % NB)*32 +: 32] = m_out[(w % NB)*32 +: 32] & ~reg_wdata;
            4: m_ren[(w % NB)*32 +: 32] = reg_wdata;
            5: m_fen[(w % NB)*32 +: 32] = reg_wdata;
            6: clr[(w % NB)*32 +: 32] = reg_wdata;
            default: ;
          endcase
        end else if (w < 9 * NB) begin
          m_alt[(w - 7*NB)*32 +: 32] = reg_wdata;
        end
      end
      m_st = (m_st & ~clr) | hits;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  function automatic logic [31:0] m_read(input int a);
    int w = a / 4;
    if (w < 7 * NB) begin
      case (w / NB)
        0: return m_s2[(w % NB)*32 +: 32];
        1: return m_dir[(w % NB)*32 +: 32];
        4: return m_ren[(w % NB)*32 +: 32];
        5: return m_fen[(w % NB)*32 +: 32];
        6: return m_st[(w % NB)*32 +: 32];
        default: return 32'h0;
      endcase
    end else if (w < 9 * NB) return m_alt[(w - 7*NB)*32 +: 32];
    return 32'h0;
  endfunction

  function automatic int adr(input int feat, input int idx);
    return (feat * NB + idx) * 4;
  endfunction

  // per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(pin_oe == m_dir, "R3 pin_oe", pin_oe, m_dir);
      check(pin_out == m_out, "R4 pin_out", pin_out, m_out);
      check(alt_sel == m_alt, "R9 alt_sel", alt_sel, m_alt);
      check(irq == m_irq, "R8 irq", irq, m_irq);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    reg_addr = ADDR_W'(a); reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    reg_addr = ADDR_W'(a);
    #1;
    check(reg_rdata == m_read(a), tag, reg_rdata, m_read(a));
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R10: reset values
    for (int a = 0; a < 9 * NB * 4; a += 4) rd(a, "R10 reset read");
    reg_addr = ADDR_W'(adr(6, 0)); #1;
    check(reg_rdata == 0, "R10 status zero", reg_rdata, 0);
    check(irq == 1'b0, "R10 irq low", irq, 0);
    @(negedge clk);

    // R1 / R3: direction per bank
    wr(adr(1, 0), 32'hA5A5_0F0F);
    wr(adr(1, 1), 32'h1234_8001);
    rd(adr(1, 0), "R1 dir bank0");
    rd(adr(1, 1), "R3 dir bank1");
    check(pin_oe[32 +: 32] == 32'h1234_8001, "R3 oe bank1", pin_oe[32 +: 32], 32'h1234_8001);

    // R4: set / clear
    wr(adr(2, 0), 32'hFF00_00F0);
    check(pin_out[31:0] == 32'hFF00_00F0, "R4 set", pin_out[31:0], 32'hFF00_00F0);
    wr(adr(3, 0), 32'h0F00_0010);
    check(pin_out[31:0] == 32'hF000_00E0, "R4 clear", pin_out[31:0], 32'hF000_00E0);
    wr(adr(2, 1), 32'h8000_0001);
    wr(adr(2, 1), 32'h0);
    wr(adr(3, 1), 32'h0);
    check(pin_out[63:32] == 32'h8000_0001, "R4 zero bits", pin_out[63:32], 32'h8000_0001);
    rd(adr(2, 1), "R4 set reads zero");
    rd(adr(3, 0), "R4 clear reads zero");

    // R2: level through synchronizer
    pin_in = 64'h0123_4567_89AB_CDEF;
    rd(adr(0, 0), "R2 level early");
    rd(adr(0, 1), "R2 level");
    idle(2);
    rd(adr(0, 0), "R2 level settled");
    rd(adr(0, 1), "R2 level settled b1");

    // R5: rising edges, only enabled pins
    pin_in = '0; idle(4);
    wr(adr(4, 0), 32'h0000_00FF);
    pin_in = 64'h0000_0001_0000_0F0F; idle(4);
    rd(adr(6, 0), "R5 rising status");
    rd(adr(6, 1), "R5 no enable no status");
    reg_addr = ADDR_W'(adr(6, 0)); #1;
    check(reg_rdata == 32'h0000_000F, "R5 literal", reg_rdata, 32'h0000_000F);
    @(negedge clk);

    // R7: zero write keeps, one write clears
    wr(adr(6, 0), 32'h0);
    rd(adr(6, 0), "R7 zero write");
    wr(adr(6, 0), 32'h0000_0003);
    rd(adr(6, 0), "R7 w1c partial");
    wr(adr(6, 0), 32'hFFFF_FFFF);
    idle(2);
    rd(adr(6, 0), "R8 cleared");

    // R6: falling and both
    wr(adr(5, 1), 32'h0000_0001);
    wr(adr(4, 1), 32'h0000_0002);
    wr(adr(5, 1), 32'h0000_0003);
    pin_in = 64'h0000_0002_0000_0F0F; idle(4);
    rd(adr(6, 1), "R6 falling status");
    pin_in = 64'h0000_0000_0000_0F0F; idle(4);
    rd(adr(6, 1), "R6 both enables");
    wr(adr(6, 1), 32'hFFFF_FFFF);

    // R7: edge coincident with clearing write
    idle(2);
    pin_in[5] = 1'b1;
    idle(2);
    wr(adr(6, 0), 32'h0000_0020);
    reg_addr = ADDR_W'(adr(6, 0)); #1;
    check(reg_rdata[5] == 1'b1, "R7 edge wins over clear", reg_rdata, 32'h20);
    @(negedge clk);
    wr(adr(6, 0), 32'h0000_0020);
    rd(adr(6, 0), "R7 cleared after");

    // R9: alternate function packing
    wr(adr(7, 0), 32'hC000_0001);
    wr(adr(7, 3), 32'h0000_0002);
    check(alt_sel[1:0] == 2'd1, "R9 pin0 code", alt_sel[1:0], 1);
    check(alt_sel[31:30] == 2'd3, "R9 pin15 code", alt_sel[31:30], 3);
    check(alt_sel[97:96] == 2'd2, "R9 pin48 code", alt_sel[97:96], 2);
    rd(adr(7, 3), "R9 readback");

    // R11: ignored writes and undefined reads
    wr(adr(0, 0), 32'hFFFF_FFFF);
    rd(adr(0, 0), "R11 level write ignored");
    wr(9 * NB * 4, 32'hFFFF_FFFF);
    wr((1 << ADDR_W) - 4, 32'hFFFF_FFFF);
    rd(9 * NB * 4, "R11 undefined read");
    rd((1 << ADDR_W) - 4, "R11 undefined top");
    for (int a = 0; a < 9 * NB * 4; a += 4) rd(a, "R1 map sweep");
    idle(3);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule